// File: doc/BRIEF.md
# One-Time Block Write-Protection Configurator

This unit sits behind the byte receive path of a serial-memory slave. It watches each write transaction and recognises two configuration commands hidden inside it. The array is divided into sixteen equal blocks, and the unit keeps three settings: the first protected block, the number of protected blocks, and the index of one high-endurance block. From these it produces a combinational write-inhibit for any address the write engine presents, and it publishes the high-endurance block index. The settings stand for nonvolatile state and are modelled as registers that take their factory values on reset.

A configuration transaction is three bytes long. The first byte carries a mode flag in bit 7 and a block field in bits 4:1. The second byte is a filler, and the third byte selects the command. A protection command may be committed only once. After it has been committed, both the protection range and the high-endurance selection are frozen. A command takes effect only when the transaction closes with a real STOP right after the third byte. Any other sequence is dropped without touching the settings.

Received bytes arrive on a valid/ready stream. `rx_ready` is held high at all times, so the unit never applies back-pressure. A byte is consumed in every cycle where `rx_valid` is high, and nothing is consumed while it is low. The transaction-end strobe takes priority over a byte offered in the same cycle, and that byte is discarded.

Top module: `blkprot_cfg`

## Requirements
- R1: After reset no address is inhibited and `he_block` equals 15.
- R2: A transaction of exactly three consumed bytes commits the protection setting when all of the following hold: the first byte has `rx_first`=1 and bit 7=1; the third byte has bit 7=1 and bit 6=0; the transaction closes with `end_valid`=1 and `end_stop`=1. The start block is first-byte bits 4:1 and the count is third-byte bits 3:0. `wr_inhibit` reflects the new setting from the clock edge that samples the end strobe.
- R3: `wr_inhibit` is 1 exactly when the block index `chk_addr[12:9]` lies from start to start+count-1, with the range clamped at block 15. A count of 0 inhibits nothing.
- R4: The values of first-byte bits 0, 5 and 6, of the whole second byte, and of third-byte bits 5:4 have no effect on either command.
- R5: Once a protection command has committed, including one with count 0, later protection commands leave the protected range unchanged.
- R6: A well-formed transaction whose third byte has bit 7=0 sets `he_block` to first-byte bits 4:1 and leaves the protection unchanged.
- R7: After a protection command has committed, high-endurance commands leave `he_block` unchanged.
- R8: No setting changes in any of these cases: the end has `end_stop`=0; two or four bytes were consumed; the third byte has bits 7:6=11; the first byte has bit 7=0.
- R9: `rx_ready` is always 1, and a cycle with `rx_valid`=0 neither counts a byte nor restarts a transaction, whatever `rx_data` and `rx_first` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset that loads the factory settings |
| rx_valid | input | 1 | A received byte is offered |
| rx_ready | output | 1 | Byte accepted; always high |
| rx_data | input | 8 | Received byte |
| rx_first | input | 1 | Marks the byte as the first address byte of a write transaction |
| end_valid | input | 1 | Transaction-end strobe |
| end_stop | input | 1 | With end_valid: 1 = closed by STOP, 0 = closed another way |
| chk_addr | input | 13 | Byte address of a pending array write |
| wr_inhibit | output | 1 | The block of chk_addr is write-protected |
| he_block | output | 4 | Index of the high-endurance block |

## Verification
The hardest state to reach is the frozen configuration. The lock can be set only once per reset, and every command sent after it must be shown to change nothing. The vector table is therefore ordered so that rejected and malformed sequences and high-endurance updates come first. A single protection commit with a clamped range follows, and after it come repeat attempts of both command kinds. Directed passes then reset the unit to commit a zero-count lock, to drop idle stream cycles into a valid command, and to sample the inhibit on both sides of the committing edge.

// File: rtl/blkprot_pkg.sv
package blkprot_pkg;
  localparam int BYTE_W   = 8;
  localparam int MODE_BIT = 7;   // set in first byte: configuration; in third byte: protection
  localparam int RSVD_BIT = 6;   // must be clear in a protection command

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_GOT1,
    SEQ_GOT2,
    SEQ_GOT3,
    SEQ_OVER
  } seq_state_t;
endpackage

// File: rtl/blkprot_seq_decode.sv
module blkprot_seq_decode
  import blkprot_pkg::*;
#(
  parameter int BLK_W   = 4,
  parameter int FLD_LSB = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_take,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_first,
  input  logic              end_valid,
  input  logic              end_stop,
  output logic              sec_commit,
  output logic              he_commit,
  output logic [BLK_W-1:0]  cmd_start,
  output logic [BLK_W-1:0]  cmd_count
);
  seq_state_t        state_q;
  logic              cfg_q;
  logic [BLK_W-1:0]  start_q;
  logic [BYTE_W-1:0] third_q;
  logic              good_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cfg_q   <= 1'b0;
      start_q <= '0;
      third_q <= '0;
    end else if (end_valid) begin
      state_q <= SEQ_IDLE;
    end else if (rx_take) begin
      if (rx_first) begin
        state_q <= SEQ_GOT1;
        cfg_q   <= rx_data[MODE_BIT];
        start_q <= rx_data[FLD_LSB +: BLK_W];
      end else begin
        case (state_q)
          SEQ_GOT1: state_q <= SEQ_GOT2;
          SEQ_GOT2: begin
            state_q <= SEQ_GOT3;
            third_q <= rx_data;
          end
          SEQ_GOT3: state_q <= SEQ_OVER;
          default:  state_q <= state_q;
        endcase
      end
    end
  end

  always_comb begin
    good_end   = end_valid && end_stop && (state_q == SEQ_GOT3) && cfg_q;
    sec_commit = good_end && third_q[MODE_BIT] && !third_q[RSVD_BIT];
    he_commit  = good_end && !third_q[MODE_BIT];
    cmd_start  = start_q;
    cmd_count  = third_q[BLK_W-1:0];
  end
endmodule

// File: rtl/blkprot_store.sv
module blkprot_store #(
  parameter int BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_commit,
  input  logic             he_commit,
  input  logic [BLK_W-1:0] cmd_start,
  input  logic [BLK_W-1:0] cmd_count,
  output logic             locked,
  output logic [BLK_W-1:0] prot_start,
  output logic [BLK_W-1:0] prot_count,
  output logic [BLK_W-1:0] he_blk
);
  localparam logic [BLK_W-1:0] TOP_BLK = {BLK_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked     <= 1'b0;
      prot_start <= TOP_BLK;
      prot_count <= '0;
      he_blk     <= TOP_BLK;
    end else if (!locked) begin
      if (sec_commit) begin
        locked     <= 1'b1;
        prot_start <= cmd_start;
        prot_count <= cmd_count;
      end else if (he_commit) begin
        he_blk <= cmd_start;
      end
    end
  end
endmodule

// File: rtl/blkprot_range.sv
module blkprot_range #(
  parameter int ADDR_W = 13,
  parameter int BLK_W  = 4
) (
  input  logic [BLK_W-1:0]  prot_start,
  input  logic [BLK_W-1:0]  prot_count,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              inhibit
);
  localparam int NBLK = 1 << BLK_W;

  logic [NBLK-1:0]  blk_hit;
  logic [BLK_W-1:0] blk_idx;

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    localparam logic [BLK_W:0] GIDX = (BLK_W+1)'(g);
    assign blk_hit[g] = (prot_count != '0)
                     && (GIDX >= {1'b0, prot_start})
                     && ((GIDX - {1'b0, prot_start}) < {1'b0, prot_count});
  end

  assign blk_idx = chk_addr[ADDR_W-1 -: BLK_W];
  assign inhibit = blk_hit[blk_idx];
endmodule

// File: rtl/blkprot_cfg.sv
module blkprot_cfg
  import blkprot_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int BLK_W   = 4,
  parameter int FLD_LSB = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_first,
  input  logic              end_valid,
  input  logic              end_stop,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              wr_inhibit,
  output logic [BLK_W-1:0]  he_block
);
  logic             rx_take;
  logic             sec_commit;
  logic             he_commit;
  logic [BLK_W-1:0] cmd_start;
  logic [BLK_W-1:0] cmd_count;
  logic             sec_locked;
  logic [BLK_W-1:0] prot_start;
  logic [BLK_W-1:0] prot_count;

  assign rx_ready = 1'b1;
  assign rx_take  = rx_valid && rx_ready;

  blkprot_seq_decode #(.BLK_W(BLK_W), .FLD_LSB(FLD_LSB)) u_dec (
    .clk(clk), .rst_n(rst_n), .rx_take(rx_take), .rx_data(rx_data),
    .rx_first(rx_first), .end_valid(end_valid), .end_stop(end_stop),
    .sec_commit(sec_commit), .he_commit(he_commit),
    .cmd_start(cmd_start), .cmd_count(cmd_count)
  );

  blkprot_store #(.BLK_W(BLK_W)) u_store (
    .clk(clk), .rst_n(rst_n), .sec_commit(sec_commit), .he_commit(he_commit),
    .cmd_start(cmd_start), .cmd_count(cmd_count), .locked(sec_locked),
    .prot_start(prot_start), .prot_count(prot_count), .he_blk(he_block)
  );

  blkprot_range #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_range (
    .prot_start(prot_start), .prot_count(prot_count),
    .chk_addr(chk_addr), .inhibit(wr_inhibit)
  );
endmodule

// File: rtl/blkprot_cfg_chk.sv
module blkprot_cfg_chk #(
  parameter int BLK_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             end_valid,
  input logic             end_stop,
  input logic             sec_locked,
  input logic [BLK_W-1:0] prot_start,
  input logic [BLK_W-1:0] prot_count,
  input logic [BLK_W-1:0] he_block,
  input logic             wr_inhibit
);
  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_locked |=> sec_locked);

  // R5
  range_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_locked |=> ($stable(prot_start) && $stable(prot_count)));

  // R7
  he_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_locked |=> $stable(he_block));

  // R8
  needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(end_valid && end_stop) |=> ($stable(he_block) && $stable(prot_start)
                                  && $stable(prot_count) && $stable(sec_locked)));

  // R3
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prot_count == '0) |-> !wr_inhibit);
endmodule

bind blkprot_cfg blkprot_cfg_chk #(.BLK_W(BLK_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .end_valid(end_valid), .end_stop(end_stop),
  .sec_locked(sec_locked), .prot_start(prot_start), .prot_count(prot_count),
  .he_block(he_block), .wr_inhibit(wr_inhibit)
);

// File: tb/test_blkprot_cfg.sv
`timescale 1ns/1ps
module test_blkprot_cfg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = '0;
  logic        rx_first = 1'b0;
  logic        end_valid = 1'b0;
  logic        end_stop = 1'b0;
  logic [12:0] chk_addr = '0;
  logic        wr_inhibit;
  logic [3:0]  he_block;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  blkprot_cfg i_blkprot_cfg (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_first(rx_first), .end_valid(end_valid),
    .end_stop(end_stop), .chk_addr(chk_addr), .wr_inhibit(wr_inhibit),
    .he_block(he_block)
  );

  // entry: b1, b2, b3, byte count, stop flag, expected mask, expected he_block
  localparam int NVEC = 10;
  localparam logic [51:0] VEC [NVEC] = '{
    {8'h05, 8'h00, 8'h00, 4'd3, 4'd1, 16'h0000, 4'd15},  // R8 plain write
    {8'h8A, 8'h5A, 8'h00, 4'd3, 4'd1, 16'h0000, 4'd5 },  // R6
    {8'h86, 8'h00, 8'h84, 4'd3, 4'd0, 16'h0000, 4'd5 },  // R8 no stop
    {8'h86, 8'h00, 8'h84, 4'd2, 4'd1, 16'h0000, 4'd5 },  // R8 short
    {8'h86, 8'h00, 8'hC4, 4'd3, 4'd1, 16'h0000, 4'd5 },  // R8 bit6 set
    {8'h86, 8'h00, 8'h84, 4'd4, 4'd1, 16'h0000, 4'd5 },  // R8 long
    {8'hE5, 8'hFF, 8'h30, 4'd3, 4'd1, 16'h0000, 4'd2 },  // R4 R6
    {8'hF7, 8'hA5, 8'hB6, 4'd3, 4'd1, 16'hF800, 4'd2 },  // R2 R3 R4 clamp
    {8'h82, 8'h00, 8'h83, 4'd3, 4'd1, 16'hF800, 4'd2 },  // R5
    {8'h80, 8'h00, 8'h00, 4'd3, 4'd1, 16'hF800, 4'd2 }   // R7
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input logic first);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_first = first;
    @(negedge clk);
    rx_valid = 1'b0; rx_first = 1'b0; rx_data = '0;
  endtask

  task automatic send_end(input logic stop);
    @(negedge clk);
    end_valid = 1'b1; end_stop = stop;
    @(negedge clk);
    end_valid = 1'b0; end_stop = 1'b0;
  endtask

  task automatic get_mask(output logic [15:0] m);
    for (int b = 0; b < 16; b++) begin
      chk_addr = {4'(b), 9'h0AB};
      #1;
      m[b] = wr_inhibit;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] m;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    get_mask(m);
    check("R1 mask", 32'(m), 32'h0);
    check("R1 he_block", 32'(he_block), 32'd15);
    check("R9 rx_ready", 32'(rx_ready), 32'd1);

    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] b1, b2, b3;
      logic [3:0] nb, st, ehe;
      logic [15:0] emask;
      {b1, b2, b3, nb, st, emask, ehe} = VEC[i];
      send_byte(b1, 1'b1);
      send_byte(b2, 1'b0);
      if (nb >= 4'd3) send_byte(b3, 1'b0);
      if (nb >= 4'd4) send_byte(b3, 1'b0);
      send_end(st[0]);
      get_mask(m);
      check($sformatf("R2/R3/R5/R8 vector %0d mask", i), 32'(m), 32'(emask));
      check($sformatf("R4/R6/R7 vector %0d he_block", i), 32'(he_block), 32'(ehe));
    end

    // R5 R7: count-0 commit still locks
    do_reset();
    get_mask(m);
    check("R1 mask after reset", 32'(m), 32'h0);
    check("R1 he_block after reset", 32'(he_block), 32'd15);
    send_byte(8'h9E, 1'b1); send_byte(8'h00, 1'b0); send_byte(8'h80, 1'b0);
    send_end(1'b1);
    get_mask(m);
    check("R3 count zero mask", 32'(m), 32'h0);
    send_byte(8'h84, 1'b1); send_byte(8'h00, 1'b0); send_byte(8'h00, 1'b0);
    send_end(1'b1);
    check("R7 he after zero lock", 32'(he_block), 32'd15);
    send_byte(8'h80, 1'b1); send_byte(8'h00, 1'b0); send_byte(8'h8F, 1'b0);
    send_end(1'b1);
    get_mask(m);
    check("R5 second commit ignored", 32'(m), 32'h0);

    // R9 idle cycles with noise, R2 commit timing
    do_reset();
    send_byte(8'h80, 1'b1);
    @(negedge clk);
    rx_valid = 1'b0; rx_data = 8'hFF; rx_first = 1'b1;
    @(negedge clk);
    rx_first = 1'b0; rx_data = 8'h00;
    send_byte(8'h00, 1'b0);
    send_byte(8'h81, 1'b0);
    @(negedge clk);
    end_valid = 1'b1; end_stop = 1'b1;
    chk_addr = 13'h0000;
    #1;
    check("R2 before commit edge", 32'(wr_inhibit), 32'd0);
    @(negedge clk);
    end_valid = 1'b0; end_stop = 1'b0;
    #1;
    check("R2 after commit edge", 32'(wr_inhibit), 32'd1);
    get_mask(m);
    check("R9 valid-low noise ignored mask", 32'(m), 32'h0001);
    check("R9 rx_ready held", 32'(rx_ready), 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule